// File: doc/BRIEF.md
# Receive FIFO Head Read Window

This block gives a processor a single memory-mapped data register through which the message at the head of a receive FIFO can be read word by word. The FIFO's elements live in a word-addressed message RAM. The block keeps a pointer into that RAM and a count of how far into the current element it has read. Each read that is allowed to have side effects returns the word at the pointer, then moves the pointer on by one word.

When the read takes the final word of an element, the block hands the element back to the FIFO. It does this by emitting the FIFO's current get index on a one-cycle acknowledge strobe. The pointer then moves to the next element's base, and wraps to the FIFO start once the last element has been read.

Reads from a debug host never change state. The same holds for reads while the controller is reconfiguring, reads while the window is disabled, and reads while the FIFO is empty. Each of these is still answered. The message RAM has one cycle of read latency, so every answer comes back registered through a ready/valid handshake.

Top module: `fifo_top_rdport`

## Requirements
- R1: After reset, `rsp_valid`, `ack_valid` and `rsp_data` are 0 and `req_ready` is 1.
- R2: With `top_en` = 1, an accepted read (`req_valid` and `req_ready` high at a rising edge) returns the RAM word at the current top address. `rsp_valid` rises on the second rising edge after acceptance, and `rsp_data` holds the RAM word.
- R3: A read with side effects happens when `req_dbg` = 0, `top_en` = 1, `cfg_change` = 0 and `fifo_fill` != 0. Each such read advances the top address by one word, so successive reads return consecutive RAM addresses within an element.
- R4: The word count of an element is 2 header words plus a payload chosen by the 3-bit `elem_dsz` code. Codes 0 to 4 give code+2 payload words, and codes 5, 6 and 7 give 8, 12 and 16 payload words. No acknowledge is issued before the element's last word has been read.
- R5: A read with side effects that takes an element's last word makes `ack_valid` high for exactly one cycle, starting after the accepting edge, with `ack_idx` equal to `fifo_get_idx`.
- R6: After an acknowledge, the next word read is the base of the following element. If the acknowledged index was `fifo_elems`-1, the next word read is `fifo_start`.
- R7: A read with `req_dbg` = 1 returns the word at the top address but neither advances the pointer nor acknowledges.
- R8: A read with `top_en` = 0 returns 0, issues no RAM read and no acknowledge.
- R9: A read with `cfg_change` = 1 returns the RAM word but has no side effect.
- R10: A read while `fifo_fill` = 0 returns the RAM word without advancing or acknowledging.
- R11: `req_ready` is low from acceptance until the response has been taken. While `rsp_valid` = 1 and `rsp_ready` = 0, `rsp_valid` and `rsp_data` hold.
- R12: While `top_en` = 0 or `cfg_change` = 1, the pointer realigns to `fifo_start` + `fifo_get_idx` × element words, and the word count returns to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| top_en | input | 1 | Read window enable |
| cfg_change | input | 1 | Controller in configuration-change mode |
| req_valid | input | 1 | Register read request |
| req_dbg | input | 1 | Request comes from a debug host |
| req_ready | output | 1 | Block can accept a read |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Response accepted by bus side |
| rsp_data | output | 32 | Read response data |
| ram_rd_en | output | 1 | Message RAM read strobe |
| ram_rd_addr | output | AW | Message RAM word address |
| ram_rd_data | input | 32 | RAM data, one cycle after strobe |
| fifo_get_idx | input | IW | Index of head element |
| fifo_fill | input | IW+1 | Number of stored elements |
| fifo_start | input | AW | RAM address of element 0 |
| fifo_elems | input | IW+1 | Number of elements in the FIFO |
| elem_dsz | input | 3 | Payload size code |
| ack_valid | output | 1 | Acknowledge strobe |
| ack_idx | output | IW | Index being acknowledged |

## Verification
The hardest state to reach from the ports is a pointer that sits partway through an element at the moment a suppressing condition arrives. This matters most at the last element, where an acknowledge must also wrap the pointer. The stimulus walks every element of a three-element FIFO to reach the wrap. It also stops reads partway through elements before dropping the enable, raising configuration change, emptying the FIFO or switching to debug reads. The bench models the FIFO's get index and fill level, updating them from the acknowledges it sees. Because of that, each expected address follows from the requirements alone.

// File: rtl/fifo_top_pkg.sv
// Shared definitions for the FIFO head read window.
// Assumes elements are stored back to back in the message RAM.
package fifo_top_pkg;
    localparam int DSZ_W  = 3;
    localparam int WCNT_W = 5;

    // Total words of one element (2 header + payload) for a size code.
    function automatic logic [WCNT_W-1:0] elem_words(input logic [DSZ_W-1:0] code);
        logic [WCNT_W-1:0] w;
        case (code)
            3'd5:    w = 5'd10;
            3'd6:    w = 5'd14;
            3'd7:    w = 5'd18;
            default: w = WCNT_W'(code) + 5'd4;
        endcase
        return w;
    endfunction
endpackage

// File: rtl/fifo_top_ptr.sv
// Top pointer and word counter of the head read window.
// Advances on each read with side effects, acknowledges on the last word
// of an element, and realigns to the head element while held.
// Assumes adv is never high in two consecutive cycles.
module fifo_top_ptr
    import fifo_top_pkg::*;
#(
    parameter int AW = 10,
    parameter int IW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              adv,
    input  logic [IW-1:0]     get_idx,
    input  logic [AW-1:0]     start,
    input  logic [IW:0]       elems,
    input  logic [DSZ_W-1:0]  dsz,
    output logic [AW-1:0]     top_addr,
    output logic              ack_valid,
    output logic [IW-1:0]     ack_idx
);
    logic [WCNT_W-1:0] word_cnt;
    logic [WCNT_W-1:0] words;
    logic              last_word;
    logic              last_elem;
    logic [AW-1:0]     head_base;

    // Element geometry and head element base address.
    always_comb begin
        words     = elem_words(dsz);
        last_word = (word_cnt == words - 1'b1);
        last_elem = (({1'b0, get_idx} + 1'b1) == elems);
        head_base = start + AW'(get_idx) * AW'(words);
    end

    // Pointer, word counter and acknowledge strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_addr  <= '0;
            word_cnt  <= '0;
            ack_valid <= 1'b0;
            ack_idx   <= '0;
        end else begin
            ack_valid <= 1'b0;
            if (hold) begin
                top_addr <= head_base;
                word_cnt <= '0;
            end else if (adv) begin
                if (last_word) begin
                    word_cnt  <= '0;
                    ack_valid <= 1'b1;
                    ack_idx   <= get_idx;
                    top_addr  <= last_elem ? start : top_addr + 1'b1;
                end else begin
                    word_cnt <= word_cnt + 1'b1;
                    top_addr <= top_addr + 1'b1;
                end
            end
        end
    end

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n) ack_valid |=> !ack_valid); // R5
    AST_NO_EARLY_ACK: assert property (@(posedge clk) disable iff (!rst_n) (adv && !hold && !last_word) |=> !ack_valid); // R4
    AST_HOLD_REALIGN: assert property (@(posedge clk) disable iff (!rst_n) (hold && $stable(head_base)) |=> (top_addr == head_base)); // R12
endmodule

// File: rtl/fifo_top_rsp.sv
// Response stage: waits one cycle for the RAM word, then holds the
// registered answer until the bus side takes it.
// Assumes issue only arrives while busy is low.
module fifo_top_rsp (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        issue,
    input  logic        issue_en,
    input  logic [31:0] ram_rd_data,
    input  logic        rsp_ready,
    output logic        busy,
    output logic        rsp_valid,
    output logic [31:0] rsp_data
);
    logic pend;
    logic pend_en;

    // Busy from acceptance until the response is consumed.
    always_comb busy = pend | rsp_valid;

    // Capture RAM data one cycle after issue; hold until taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend      <= 1'b0;
            pend_en   <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            if (issue) begin
                pend    <= 1'b1;
                pend_en <= issue_en;
            end else if (pend) begin
                pend      <= 1'b0;
                rsp_valid <= 1'b1;
                rsp_data  <= pend_en ? ram_rd_data : 32'h0;
            end else if (rsp_valid && rsp_ready) begin
                rsp_valid <= 1'b0;
            end
        end
    end

    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R11
endmodule

// File: rtl/fifo_top_rdport.sv
// FIFO head read window: a register read port that steps through the
// words of the head element and acknowledges it after its last word.
// Assumes the FIFO updates get index and fill level after an acknowledge.
module fifo_top_rdport
    import fifo_top_pkg::*;
#(
    parameter int AW = 10,
    parameter int IW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              top_en,
    input  logic              cfg_change,
    input  logic              req_valid,
    input  logic              req_dbg,
    output logic              req_ready,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [31:0]       rsp_data,
    output logic              ram_rd_en,
    output logic [AW-1:0]     ram_rd_addr,
    input  logic [31:0]       ram_rd_data,
    input  logic [IW-1:0]     fifo_get_idx,
    input  logic [IW:0]       fifo_fill,
    input  logic [AW-1:0]     fifo_start,
    input  logic [IW:0]       fifo_elems,
    input  logic [DSZ_W-1:0]  elem_dsz,
    output logic              ack_valid,
    output logic [IW-1:0]     ack_idx
);
    logic          busy;
    logic          accept;
    logic          adv;
    logic          hold;
    logic [AW-1:0] top_addr;

    // Request acceptance, RAM access and side-effect qualification.
    always_comb begin
        req_ready   = !busy;
        accept      = req_valid && !busy;
        hold        = !top_en || cfg_change;
        ram_rd_en   = accept && top_en;
        ram_rd_addr = top_addr;
        adv         = accept && !req_dbg && !hold && (fifo_fill != '0);
    end

    fifo_top_ptr #(.AW(AW), .IW(IW)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (hold),
        .adv       (adv),
        .get_idx   (fifo_get_idx),
        .start     (fifo_start),
        .elems     (fifo_elems),
        .dsz       (elem_dsz),
        .top_addr  (top_addr),
        .ack_valid (ack_valid),
        .ack_idx   (ack_idx)
    );

    fifo_top_rsp u_rsp (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue       (accept),
        .issue_en    (top_en),
        .ram_rd_data (ram_rd_data),
        .rsp_ready   (rsp_ready),
        .busy        (busy),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data)
    );

    AST_DBG_STILL: assert property (@(posedge clk) disable iff (!rst_n) (accept && req_dbg && !hold) |=> ($stable(top_addr) && !ack_valid)); // R7
    AST_EMPTY_STILL: assert property (@(posedge clk) disable iff (!rst_n) (accept && fifo_fill == '0 && !hold) |=> ($stable(top_addr) && !ack_valid)); // R10
    AST_OFF_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n) (accept && !top_en) |=> !ack_valid); // R8
endmodule

// File: tb/fifo_top_rdport_bench.sv
`timescale 1ns/1ps
module fifo_top_rdport_bench;
    localparam int AW = 10;
    localparam int IW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic top_en = 1'b0, cfg_change = 1'b0;
    logic req_valid = 1'b0, req_dbg = 1'b0, rsp_ready = 1'b1;
    logic req_ready, rsp_valid, ram_rd_en, ack_valid;
    logic [31:0] rsp_data, ram_q;
    logic [AW-1:0] ram_rd_addr;
    logic [IW-1:0] get_idx = '0, ack_idx;
    logic [IW:0] fill = '0, elems = 4'd3;
    logic [AW-1:0] start = 10'h100;
    logic [2:0] dsz = 3'd0;

    int vectors = 0, errors = 0, ack_cnt = 0, ram_cnt = 0;
    logic [IW-1:0] last_ack = '0;

    always #2.5 clk = ~clk;

    fifo_top_rdport #(.AW(AW), .IW(IW)) u_fifo_top_rdport (
        .clk(clk), .rst_n(rst_n), .top_en(top_en), .cfg_change(cfg_change),
        .req_valid(req_valid), .req_dbg(req_dbg), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
        .ram_rd_en(ram_rd_en), .ram_rd_addr(ram_rd_addr), .ram_rd_data(ram_q),
        .fifo_get_idx(get_idx), .fifo_fill(fill), .fifo_start(start),
        .fifo_elems(elems), .elem_dsz(dsz), .ack_valid(ack_valid), .ack_idx(ack_idx)
    );

    function automatic logic [31:0] word_at(input logic [AW-1:0] a);
        return {16'hC0DE, 6'b0, a};
    endfunction

    // Message RAM model with one cycle of latency.
    always @(posedge clk) begin
        if (ram_rd_en) begin
            ram_q   <= word_at(ram_rd_addr);
            ram_cnt <= ram_cnt + 1;
        end
    end

    // FIFO model: consume the acknowledged element.
    always @(negedge clk) begin
        if (ack_valid) begin
            ack_cnt  <= ack_cnt + 1;
            last_ack <= ack_idx;
            get_idx  <= ({1'b0, get_idx} + 1'b1 == elems) ? '0 : get_idx + 1'b1;
            fill     <= fill - 1'b1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FIFO-BENCH FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_read(input logic dbg, output logic [31:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_dbg   = dbg;
        @(negedge clk);
        req_valid = 1'b0;
        req_dbg   = 1'b0;
        while (!rsp_valid) @(negedge clk);
        d = rsp_data;
        @(negedge clk);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1 rsp_valid", 32'(rsp_valid), 0);
        check("R1 ack_valid", 32'(ack_valid), 0);
        check("R1 rsp_data", rsp_data, 0);
        check("R1 req_ready", 32'(req_ready), 1);
    endtask

    task automatic t_walk;
        logic [31:0] d;
        settle(2);
        top_en = 1'b1; fill = 4'd3;
        for (int e = 0; e < 3; e++) begin
            for (int w = 0; w < 4; w++) begin
                do_read(1'b0, d);
                check("R2 R3 word", d, word_at(start + AW'(e * 4 + w)));
                if (w < 3) check("R4 no early ack", 32'(ack_cnt), 32'(e));
            end
            check("R5 ack count", 32'(ack_cnt), 32'(e + 1));
            check("R5 ack index", 32'(last_ack), 32'(e));
        end
        fill = 4'd1;
        do_read(1'b0, d);
        check("R6 wrap to start", d, word_at(start));
    endtask

    task automatic t_size;
        logic [31:0] d;
        int a0;
        top_en = 1'b0; dsz = 3'd5;
        settle(2);
        top_en = 1'b1;
        a0 = ack_cnt;
        for (int w = 0; w < 10; w++) begin
            do_read(1'b0, d);
            check("R4 code5 word", d, word_at(start + AW'(w)));
            if (w < 9) check("R4 code5 no early ack", 32'(ack_cnt), 32'(a0));
        end
        check("R4 code5 ack", 32'(ack_cnt), 32'(a0 + 1));
        top_en = 1'b0; dsz = 3'd0;
        settle(2);
        top_en = 1'b1; fill = 4'd2;
    endtask

    task automatic t_debug;
        logic [31:0] d;
        int a0;
        a0 = ack_cnt;
        do_read(1'b1, d);
        check("R7 dbg data", d, word_at(10'h104));
        do_read(1'b1, d);
        check("R7 dbg no advance", d, word_at(10'h104));
        do_read(1'b0, d);
        check("R7 normal after dbg", d, word_at(10'h104));
        do_read(1'b0, d);
        check("R3 next word", d, word_at(10'h105));
        check("R7 no ack", 32'(ack_cnt), 32'(a0));
    endtask

    task automatic t_disabled;
        logic [31:0] d;
        int r0, a0;
        top_en = 1'b0;
        r0 = ram_cnt; a0 = ack_cnt;
        do_read(1'b0, d);
        check("R8 zero data", d, 0);
        check("R8 no RAM read", 32'(ram_cnt), 32'(r0));
        check("R8 no ack", 32'(ack_cnt), 32'(a0));
        top_en = 1'b1;
        do_read(1'b0, d);
        check("R12 realign after disable", d, word_at(10'h104));
    endtask

    task automatic t_cfg;
        logic [31:0] d;
        cfg_change = 1'b1;
        settle(1);
        do_read(1'b0, d);
        check("R9 data in cfg", d, word_at(10'h104));
        do_read(1'b0, d);
        check("R9 no advance", d, word_at(10'h104));
        cfg_change = 1'b0;
        do_read(1'b0, d);
        check("R9 resume", d, word_at(10'h104));
        do_read(1'b0, d);
        check("R3 advance after cfg", d, word_at(10'h105));
    endtask

    task automatic t_empty;
        logic [31:0] d;
        int a0;
        fill = '0; a0 = ack_cnt;
        do_read(1'b0, d);
        check("R10 data when empty", d, word_at(10'h106));
        do_read(1'b0, d);
        check("R10 no advance", d, word_at(10'h106));
        check("R10 no ack", 32'(ack_cnt), 32'(a0));
    endtask

    task automatic t_hold;
        fill = 4'd1; rsp_ready = 1'b0;
        @(negedge clk);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R11 busy after accept", 32'(req_ready), 0);
        @(negedge clk);
        check("R2 valid on second edge", 32'(rsp_valid), 1);
        settle(3);
        check("R11 still valid", 32'(rsp_valid), 1);
        check("R11 data held", rsp_data, word_at(10'h106));
        check("R11 not ready", 32'(req_ready), 0);
        rsp_ready = 1'b1;
        settle(1);
        check("R11 released", 32'(rsp_valid), 0);
        check("R11 ready again", 32'(req_ready), 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FIFO-BENCH FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_walk();
        t_size();
        t_debug();
        t_disabled();
        t_cfg();
        t_empty();
        t_hold();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule